// File: doc/BRIEF.md
# Processor Clock Idle Gate

This block produces the clock for a processor core from the free-running system clock and can stop it to put the core into an idle state. Software controls it through three small registers: a set register that turns the processor clock on, a clear register that asks for it to be turned off, and a read-only status register that shows whether the clock is running. A clear request does not stop the clock at once. The gate waits until the core signals that its current instruction has completed, and only then removes clock pulses. It does this without glitches, by changing the gate enable only while the system clock is low.

Once stopped, the clock comes back on its own when any enabled interrupt arrives. This can be a normal request or a fast request, each masked by its own enable vector. Reset also brings the clock back, as does a write to the set register. The system bus clock is passed through untouched, so other bus masters keep transferring data while the core idles.

Top module: `cpu_idle_gate`

## Requirements
- R1: Reset is synchronous and active high. During and after reset the processor clock runs and no stop request is pending.
- R2: A write to the clear register (address 1) requests a stop when wr_data and wr_mask both have a one at bit CPU_BIT. The clock stops on the first clock edge at which that request, or an earlier pending one, is seen together with insn_done high. A stop seen on the same edge as the write is allowed.
- R3: While a stop is pending and insn_done is low, the processor clock keeps running.
- R4: A stopped clock restarts one cycle after any normal interrupt request whose enable bit is set. A request whose enable bit is clear has no effect.
- R5: A stopped clock restarts one cycle after any fast interrupt request whose enable bit is set.
- R6: An enabled interrupt seen on the same edge as a clear-register write wins. The clock stays running and the stop request is discarded, so a later insn_done does not stop it.
- R7: A write takes effect only for a bit that has a one in both wr_data and wr_mask. A write with bit CPU_BIT clear in either has no effect, and so does a write to the status address (2).
- R8: A write to the set register (address 0) with bit CPU_BIT in data and mask set restarts a stopped clock and cancels a pending stop.
- R9: cpu_clk is low for every system clock cycle after the stop takes effect and follows clk while running. bus_clk always equals clk.
- R10: A read returns rd_valid and rd_data one cycle after rd_en. At the status address (2), bit CPU_BIT is 1 when the clock runs and 0 when it is stopped, and all other bits are 0. Reads of addresses 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 set, 1 clear, 2 status |
| wr_data | input | DATA_W | Write data |
| wr_mask | input | DATA_W | Per-bit write mask |
| rd_en | input | 1 | One-cycle register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| insn_done | input | 1 | Core reports that the current instruction has completed |
| irq_req | input | NUM_IRQ | Normal interrupt requests |
| irq_en | input | NUM_IRQ | Normal interrupt enables |
| fiq_req | input | NUM_FIQ | Fast interrupt requests |
| fiq_en | input | NUM_FIQ | Fast interrupt enables |
| cpu_clk | output | 1 | Gated processor clock |
| bus_clk | output | 1 | Ungated system bus clock |

## Verification
The bench builds the gate with CPU_BIT at 3, four normal interrupt lines and one fast line. A non-zero control bit catches any decoder that tests bit 0 or ignores the mask. The small vectors make it quick to show that a single masked line is ignored while a single enabled line wakes the core. The sequences cover a deferred stop held off by a low insn_done, a stop that completes on the same edge as the write, and an interrupt racing a clear write. They also include cancellation through the set register.

// File: rtl/cpu_idle_pkg.sv
package cpu_idle_pkg;
  localparam int unsigned REG_SET    = 0;
  localparam int unsigned REG_CLEAR  = 1;
  localparam int unsigned REG_STATUS = 2;
endpackage

// File: rtl/cpu_idle_regs.sv
module cpu_idle_regs #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned CPU_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_mask,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              run_q,
  output logic              en_req,
  output logic              dis_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  import cpu_idle_pkg::*;

  logic bit_hit;
  assign bit_hit = wr_en & wr_data[CPU_BIT] & wr_mask[CPU_BIT];
  assign en_req  = bit_hit && (wr_addr == ADDR_W'(REG_SET));
  assign dis_req = bit_hit && (wr_addr == ADDR_W'(REG_CLEAR));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= '0;
        if (rd_addr == ADDR_W'(REG_STATUS)) rd_data[CPU_BIT] <= run_q;
      end
    end
  end
endmodule

// File: rtl/cpu_idle_wake.sv
module cpu_idle_wake #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned NUM_FIQ = 2
) (
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_FIQ-1:0] fiq_req,
  input  logic [NUM_FIQ-1:0] fiq_en,
  output logic               wake
);
  logic [NUM_IRQ-1:0] irq_live;
  logic [NUM_FIQ-1:0] fiq_live;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign irq_live[i] = irq_req[i] & irq_en[i];
  end
  for (genvar j = 0; j < NUM_FIQ; j++) begin : g_fiq
    assign fiq_live[j] = fiq_req[j] & fiq_en[j];
  end

  assign wake = (|irq_live) | (|fiq_live);
endmodule

// File: rtl/cpu_idle_ctl.sv
module cpu_idle_ctl (
  input  logic clk,
  input  logic rst,
  input  logic en_req,
  input  logic dis_req,
  input  logic wake,
  input  logic insn_done,
  output logic run_q,
  output logic pend_q
);
  logic stop_now;
  assign stop_now = run_q & (pend_q | dis_req) & insn_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b1;
      pend_q <= 1'b0;
    end else if (wake || en_req) begin
      run_q  <= 1'b1;
      pend_q <= 1'b0;
    end else if (stop_now) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (dis_req && run_q) begin
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cpu_idle_cgate.sv
module cpu_idle_cgate (
  input  logic clk,
  input  logic rst,
  input  logic run_q,
  output logic gclk
);
  logic en_low;

  always_ff @(negedge clk) begin
    if (rst) en_low <= 1'b1;
    else     en_low <= run_q;
  end

  assign gclk = clk & en_low;
endmodule

// File: rtl/cpu_idle_gate.sv
module cpu_idle_gate #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned CPU_BIT = 0,
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned NUM_FIQ = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [DATA_W-1:0]  wr_mask,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  input  logic               insn_done,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_FIQ-1:0] fiq_req,
  input  logic [NUM_FIQ-1:0] fiq_en,
  output logic               cpu_clk,
  output logic               bus_clk
);
  logic en_req, dis_req, wake, run_q, pend_q;

  cpu_idle_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CPU_BIT(CPU_BIT)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_en(rd_en), .rd_addr(rd_addr), .run_q(run_q),
    .en_req(en_req), .dis_req(dis_req), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  cpu_idle_wake #(.NUM_IRQ(NUM_IRQ), .NUM_FIQ(NUM_FIQ)) wake_i (
    .irq_req(irq_req), .irq_en(irq_en), .fiq_req(fiq_req), .fiq_en(fiq_en),
    .wake(wake)
  );

  cpu_idle_ctl ctl_i (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req), .wake(wake),
    .insn_done(insn_done), .run_q(run_q), .pend_q(pend_q)
  );

  cpu_idle_cgate cgate_i (
    .clk(clk), .rst(rst), .run_q(run_q), .gclk(cpu_clk)
  );

  assign bus_clk = clk;
endmodule

// File: rtl/cpu_idle_gate_chk.sv
module cpu_idle_gate_chk (
  input logic clk,
  input logic rst,
  input logic en_req,
  input logic dis_req,
  input logic wake,
  input logic insn_done,
  input logic run_q,
  input logic pend_q,
  input logic rd_en,
  input logic rd_valid
);
  assert_reset_runs_R1: assert property (@(posedge clk)
    rst |=> (run_q && !pend_q));

  assert_stop_on_done_R2: assert property (@(posedge clk) disable iff (rst)
    (run_q && (pend_q || dis_req) && insn_done && !wake && !en_req) |=> !run_q);

  assert_hold_until_done_R3: assert property (@(posedge clk) disable iff (rst)
    (run_q && !insn_done) |=> run_q);

  assert_wake_restarts_R4: assert property (@(posedge clk) disable iff (rst)
    (!run_q && wake) |=> run_q);

  assert_irq_beats_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (dis_req && wake) |=> (run_q && !pend_q));

  assert_set_cancels_R8: assert property (@(posedge clk) disable iff (rst)
    en_req |=> (run_q && !pend_q));

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

bind cpu_idle_gate cpu_idle_gate_chk chk_i (
  .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req), .wake(wake),
  .insn_done(insn_done), .run_q(run_q), .pend_q(pend_q),
  .rd_en(rd_en), .rd_valid(rd_valid)
);

// File: tb/cpu_idle_gate_tb.sv
module cpu_idle_gate_tb_top;
  localparam int CLK_P = 10;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam int CB = 3;
  localparam int NI = 4;
  localparam int NF = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, insn_done = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, wr_mask = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, cpu_clk, bus_clk;
  logic [NI-1:0] irq_req = '0, irq_en = '0;
  logic [NF-1:0] fiq_req = '0, fiq_en = '0;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  cpu_idle_gate #(.DATA_W(DW), .ADDR_W(AW), .CPU_BIT(CB), .NUM_IRQ(NI), .NUM_FIQ(NF)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .insn_done(insn_done), .irq_req(irq_req), .irq_en(irq_en),
    .fiq_req(fiq_req), .fiq_en(fiq_en), .cpu_clk(cpu_clk), .bus_clk(bus_clk)
  );

  localparam logic [DW-1:0] CPU_ONE = DW'(1) << CB;

  task automatic wr(input int a, input logic [DW-1:0] d, input logic [DW-1:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_clk(input logic e, input string t);
    @(posedge clk);
    #2;
    checks++;
    if (cpu_clk !== e || bus_clk !== 1'b1) begin
      errors++;
      $display("FAIL %s cpu_clk=%b bus_clk=%b expected cpu_clk=%b bus_clk=1", t, cpu_clk, bus_clk, e);
    end
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected read data %h expected none", rd_data);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s rd_data=%h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    chk_clk(1'b1, "R1 clock during reset");
    rst = 1'b0;
    idle(1);
    chk_clk(1'b1, "R1 clock after reset");
    rd(2, CPU_ONE, "R1 R10 status after reset");
    rd(0, '0, "R10 set register reads zero");
    rd(1, '0, "R10 clear register reads zero");

    // Deferred stop
    wr(1, CPU_ONE, CPU_ONE);
    idle(3);
    chk_clk(1'b1, "R3 pending stop waits for insn_done");
    rd(2, CPU_ONE, "R3 status while pending");
    @(negedge clk) insn_done = 1'b1;
    @(negedge clk) insn_done = 1'b0;
    idle(1);
    chk_clk(1'b0, "R2 R9 clock stopped after insn_done");
    chk_clk(1'b0, "R9 clock stays low");
    rd(2, '0, "R2 R10 status stopped");

    // Masked then enabled normal interrupt
    @(negedge clk) irq_req = 4'b0010;
    idle(3);
    chk_clk(1'b0, "R4 masked interrupt ignored");
    @(negedge clk) irq_en = 4'b0010;
    idle(1);
    chk_clk(1'b1, "R4 enabled interrupt restarts");
    @(negedge clk) begin irq_req = '0; irq_en = '0; end
    rd(2, CPU_ONE, "R4 status after wake");

    // Same-edge stop, then fast interrupt
    @(negedge clk) insn_done = 1'b1;
    wr(1, CPU_ONE, CPU_ONE);
    insn_done = 1'b0;
    idle(1);
    chk_clk(1'b0, "R2 stop on same edge as write");
    @(negedge clk) begin fiq_en = 1'b1; fiq_req = 1'b1; end
    @(negedge clk) fiq_req = 1'b0;
    idle(1);
    chk_clk(1'b1, "R5 fast interrupt restarts");

    // Interrupt racing a clear write
    @(negedge clk) begin irq_en = 4'b1000; irq_req = 4'b1000; end
    wr(1, CPU_ONE, CPU_ONE);
    irq_req = '0;
    @(negedge clk) insn_done = 1'b1;
    @(negedge clk) insn_done = 1'b0;
    idle(1);
    chk_clk(1'b1, "R6 interrupt beats stop request");
    rd(2, CPU_ONE, "R6 status still running");

    // Ignored writes
    insn_done = 1'b1;
    wr(1, CPU_ONE, ~CPU_ONE);
    idle(1);
    chk_clk(1'b1, "R7 mask bit clear ignored");
    wr(1, ~CPU_ONE, '1);
    idle(1);
    chk_clk(1'b1, "R7 data bit clear ignored");
    wr(2, '1, '1);
    idle(1);
    chk_clk(1'b1, "R7 write to status ignored");
    insn_done = 1'b0;
    rd(2, CPU_ONE, "R7 status unchanged");

    // Set register cancels pending, then restarts stopped
    wr(1, CPU_ONE, CPU_ONE);
    wr(0, CPU_ONE, CPU_ONE);
    @(negedge clk) insn_done = 1'b1;
    @(negedge clk) insn_done = 1'b0;
    idle(1);
    chk_clk(1'b1, "R8 set cancels pending stop");
    @(negedge clk) insn_done = 1'b1;
    wr(1, CPU_ONE, CPU_ONE);
    insn_done = 1'b0;
    idle(1);
    chk_clk(1'b0, "R8 stopped before set");
    wr(0, CPU_ONE, CPU_ONE);
    idle(1);
    chk_clk(1'b1, "R8 set restarts clock");
    rd(2, CPU_ONE, "R8 status running");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 reads outstanding=%0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule